// File: doc/BRIEF.md
# Descending Round-Robin Unit Selector

This block hands out one execution unit at a time from a group of up to `N` interchangeable units. Each unit is one bit position, so a grant is always a one-hot vector. A requester either asks the block to pick a unit itself (dynamic pick) or names a unit it has already chosen and wants consumed (static consume). Dynamic picks walk the group from the highest-numbered unit downwards. The walk is held in a sequence mask. The highest set bit is granted and then cleared. When the mask runs empty it is refilled from the member set. A unit consumed statically is also removed from the walk. If the walk had already passed that unit, the unit is noted in a removed mask and left out of the next refill only.

The block also tracks which units are idle in a ready mask. Per-unit use and release strobes update that mask. A query tells the requester whether the group is unreserved and holds at least a requested number of idle units.

Group membership comes from a parameter at reset, or from a configuration load. A load gives either a unit count K, which makes the low K positions members, or a group mask, whose highest set bit is dropped to form the member set.

The sequencer has two named states. `SEQ_FRESH` means the sequence mask was loaded or refilled and no unit has been taken since. `SEQ_DRAIN` means at least one unit has been taken since then. The transitions are:
- *take* (FRESH or DRAIN to DRAIN): a pick or consume that leaves the mask non-empty.
- *refill* (to FRESH): a pick or consume that empties the mask.
- *load* (any state to FRESH): a reset or a configuration load.

Top module: `rr_unit_selector`

## Requirements
- R1: Synchronous active-low reset loads the parameter member set into both the sequence mask and the ready mask, and empties the removed mask. With no request, `grant_o` is 0.
- R2: In count mode the member set is the low `cfg_units` bit positions. In group mode it is `cfg_group_mask` with its highest set bit cleared. A member set that comes out empty is replaced by unit 0 alone.
- R3: A dynamic pick (`req_valid`=1, `req_static`=0) drives `grant_o` in the same cycle to the highest set bit of the sequence mask. After the clock edge that bit is cleared.
- R4: Repeated dynamic picks grant the members in strictly descending bit order, then start over from the highest member.
- R5: When a pick or consume empties the sequence mask, the mask is refilled with the member set minus the removed mask, and the removed mask is emptied in the same edge.
- R6: A static consume (`req_valid`=1, `req_static`=1, one-hot `req_unit`) grants `req_unit` unchanged and clears that bit from the sequence mask if it is set.
- R7: A static consume of a unit whose sequence bit is already clear leaves the sequence mask unchanged. That unit is then absent from the next refill only and returns in the refill after it.
- R8: A bit of `use_i` clears that unit's ready bit, and a bit of `rel_i` sets it, visible one cycle later.
- R9: `misuse_o` is high in the same cycle when any unit is used while not ready, released while ready, or both used and released. Such units keep their ready bit.
- R10: `ready_o` is high exactly when `reserved_i` is 0 and the number of set ready bits is at least `need_cnt`.
- R11: `cfg_load` recomputes the member set and, after the edge, sets the sequence and ready masks to it and empties the removed mask. A request or use/release in that cycle is ignored and `grant_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load a new member set this cycle |
| cfg_is_group | input | 1 | 1: group-mask mode, 0: unit-count mode |
| cfg_units | input | CW | Unit count for count mode |
| cfg_group_mask | input | N | Group mask for group mode |
| req_valid | input | 1 | Request strobe |
| req_static | input | 1 | 1: consume `req_unit`, 0: dynamic pick |
| req_unit | input | N | One-hot unit for a static consume |
| grant_o | output | N | One-hot granted unit (combinational) |
| use_i | input | N | Per-unit mark-used strobes |
| rel_i | input | N | Per-unit release strobes |
| misuse_o | output | 1 | Illegal use/release seen this cycle |
| need_cnt | input | CW | Units requested for the ready query |
| reserved_i | input | 1 | Group is reserved |
| ready_o | output | 1 | Ready query result |
| ready_mask_o | output | N | Current idle-unit mask |
| seq_mask_o | output | N | Current sequence mask |

## Verification
Two things can land on the same clock edge: the pick that drains the sequence mask, and the refill that applies and empties the removed mask. The bench provokes this by consuming an already-passed unit statically and then picking until the mask drains. It judges the result by checking that the refilled mask lacks exactly that unit, and that the following refill contains it again. A configuration load is also driven together with a pick request. The bench expects a zero grant and a sequence mask equal to the new member set.

// File: rtl/rus_pkg.sv
package rus_pkg;
    typedef enum logic {
        SEQ_FRESH = 1'b0,
        SEQ_DRAIN = 1'b1
    } rus_seq_state_e;
endpackage

// File: rtl/rus_member_calc.sv
module rus_member_calc #(
    parameter int N  = 8,
    parameter int CW = 4
) (
    input  logic          is_group,
    input  logic [CW-1:0] units,
    input  logic [N-1:0]  group_mask,
    output logic [N-1:0]  members
);
    logic [N-1:0] top;
    logic [N-1:0] low;
    logic [N-1:0] raw;

    always_comb begin
        top = '0;
        for (int i = 0; i < N; i++) begin
            if (group_mask[i]) begin
                top    = '0;
                top[i] = 1'b1;
            end
        end
        for (int i = 0; i < N; i++) begin
            low[i] = (i < int'(units));
        end
        raw     = is_group ? (group_mask ^ top) : low;
        members = (raw == '0) ? {{(N-1){1'b0}}, 1'b1} : raw;
    end
endmodule

// File: rtl/rus_sequencer.sv
module rus_sequencer
    import rus_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rst_members,
    input  logic         load,
    input  logic [N-1:0] load_members,
    input  logic [N-1:0] members,
    input  logic         pick_dyn,
    input  logic         pick_static,
    input  logic [N-1:0] static_unit,
    output logic [N-1:0] grant_o,
    output logic [N-1:0] seq_o
);
    rus_seq_state_e state_q, state_n;
    logic [N-1:0] seq_q, seq_n;
    logic [N-1:0] rem_q, rem_n;
    logic [N-1:0] top;
    logic         refill;

    always_comb begin
        top = '0;
        for (int i = 0; i < N; i++) begin
            if (seq_q[i]) begin
                top    = '0;
                top[i] = 1'b1;
            end
        end
    end

    always_comb begin
        seq_n  = seq_q;
        rem_n  = rem_q;
        refill = 1'b0;
        if (pick_dyn) begin
            seq_n = seq_q & ~top;
        end else if (pick_static) begin
            if ((seq_q & static_unit) != '0) seq_n = seq_q & ~static_unit;
            else                             rem_n = rem_q | static_unit;
        end
        if ((pick_dyn || pick_static) && seq_n == '0) begin
            refill = 1'b1;
            seq_n  = members & ~rem_q;
            rem_n  = '0;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SEQ_FRESH: if (pick_dyn || pick_static) state_n = refill ? SEQ_FRESH : SEQ_DRAIN;
            SEQ_DRAIN: if (refill)                  state_n = SEQ_FRESH;
            default:                                state_n = SEQ_FRESH;
        endcase
        if (load) state_n = SEQ_FRESH;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_FRESH;
            seq_q   <= rst_members;
            rem_q   <= '0;
        end else if (load) begin
            state_q <= state_n;
            seq_q   <= load_members;
            rem_q   <= '0;
        end else begin
            state_q <= state_n;
            seq_q   <= seq_n;
            rem_q   <= rem_n;
        end
    end

    always_comb begin
        unique case (1'b1)
            pick_static: grant_o = static_unit;
            pick_dyn:    grant_o = top;
            default:     grant_o = '0;
        endcase
        seq_o = seq_q;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        pick_dyn |-> $onehot0(grant_o)); // R3
    AST_PICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_dyn && !load && seq_q != grant_o) |=>
        seq_q == ($past(seq_q) & ~$past(grant_o))); // R3
    AST_REFILL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_dyn && !load && seq_q == grant_o) |=>
        (seq_q == ($past(members) & ~$past(rem_q)))); // R5
    AST_REFILL_EMPTIES_REMOVED: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_dyn && !load && seq_q == grant_o) |=> rem_q == '0); // R5
    AST_SEQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q != '0); // R5
    AST_STATIC_PASSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_static && !load && (seq_q & static_unit) == '0) |=> $stable(seq_q)); // R7
    AST_FRESH_WITHIN_MEMBERS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_FRESH) |-> (seq_q & ~members) == '0); // R11
endmodule

// File: rtl/rus_readiness.sv
module rus_readiness #(
    parameter int N  = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  rst_members,
    input  logic          load,
    input  logic [N-1:0]  load_members,
    input  logic [N-1:0]  use_i,
    input  logic [N-1:0]  rel_i,
    input  logic [CW-1:0] need_cnt,
    input  logic          reserved_i,
    output logic [N-1:0]  ready_mask_o,
    output logic          misuse_o,
    output logic          ready_o
);
    logic [N-1:0] ready_q;
    logic [N-1:0] bad;
    logic [N-1:0] flip;
    int           idle_cnt;

    always_comb begin
        bad      = (use_i & ~ready_q) | (rel_i & ready_q) | (use_i & rel_i);
        flip     = (use_i | rel_i) & ~bad;
        misuse_o = (bad != '0) && !load;
        idle_cnt = 0;
        for (int i = 0; i < N; i++) idle_cnt += int'(ready_q[i]);
        ready_o      = !reserved_i && (idle_cnt >= int'(need_cnt));
        ready_mask_o = ready_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     ready_q <= rst_members;
        else if (load)  ready_q <= load_members;
        else            ready_q <= ready_q ^ flip;
    end

    AST_READY_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !misuse_o) |=> ready_q == $past(ready_q ^ use_i ^ rel_i)); // R8
    AST_MISUSE_KEEPS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (misuse_o && !load) |=> ((ready_q ^ $past(ready_q)) & $past(bad)) == '0); // R9
endmodule

// File: rtl/rr_unit_selector.sv
module rr_unit_selector #(
    parameter int          N              = 8,
    parameter bit          DEF_IS_GROUP   = 1'b0,
    parameter int          DEF_UNITS      = 4,
    parameter logic [N-1:0] DEF_GROUP_MASK = '0,
    localparam int         CW             = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic          cfg_is_group,
    input  logic [CW-1:0] cfg_units,
    input  logic [N-1:0]  cfg_group_mask,
    input  logic          req_valid,
    input  logic          req_static,
    input  logic [N-1:0]  req_unit,
    output logic [N-1:0]  grant_o,
    input  logic [N-1:0]  use_i,
    input  logic [N-1:0]  rel_i,
    output logic          misuse_o,
    input  logic [CW-1:0] need_cnt,
    input  logic          reserved_i,
    output logic          ready_o,
    output logic [N-1:0]  ready_mask_o,
    output logic [N-1:0]  seq_mask_o
);
    logic [N-1:0] def_members;
    logic [N-1:0] cfg_members;
    logic [N-1:0] members_q;
    logic         pick_dyn;
    logic         pick_static;

    rus_member_calc #(.N(N), .CW(CW)) u_def_calc (
        .is_group   (DEF_IS_GROUP),
        .units      (CW'(DEF_UNITS)),
        .group_mask (DEF_GROUP_MASK),
        .members    (def_members)
    );

    rus_member_calc #(.N(N), .CW(CW)) u_cfg_calc (
        .is_group   (cfg_is_group),
        .units      (cfg_units),
        .group_mask (cfg_group_mask),
        .members    (cfg_members)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        members_q <= def_members;
        else if (cfg_load) members_q <= cfg_members;
    end

    assign pick_dyn    = req_valid && !req_static && !cfg_load;
    assign pick_static = req_valid &&  req_static && !cfg_load;

    rus_sequencer #(.N(N)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .rst_members  (def_members),
        .load         (cfg_load),
        .load_members (cfg_members),
        .members      (members_q),
        .pick_dyn     (pick_dyn),
        .pick_static  (pick_static),
        .static_unit  (req_unit),
        .grant_o      (grant_o),
        .seq_o        (seq_mask_o)
    );

    rus_readiness #(.N(N), .CW(CW)) u_rdy (
        .clk          (clk),
        .rst_n        (rst_n),
        .rst_members  (def_members),
        .load         (cfg_load),
        .load_members (cfg_members),
        .use_i        (use_i),
        .rel_i        (rel_i),
        .need_cnt     (need_cnt),
        .reserved_i   (reserved_i),
        .ready_mask_o (ready_mask_o),
        .misuse_o     (misuse_o),
        .ready_o      (ready_o)
    );

    AST_LOAD_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (seq_mask_o == ready_mask_o) && (seq_mask_o == members_q)); // R11
    AST_LOAD_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |-> grant_o == '0); // R11
endmodule

// File: tb/rr_unit_selector_bench.sv
module rr_unit_selector_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int CW = 4;

    typedef struct {
        string      tag;
        logic [7:0] g;
        logic       mis;
        logic       rq;
        logic [7:0] seq;
        logic [7:0] rdy;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 0, cfg_is_group = 0, req_valid = 0, req_static = 0, reserved_i = 0;
    logic [CW-1:0] cfg_units = '0, need_cnt = '0;
    logic [N-1:0] cfg_group_mask = '0, req_unit = '0, use_i = '0, rel_i = '0;
    logic [N-1:0] grant_o, ready_mask_o, seq_mask_o;
    logic misuse_o, ready_o;

    int n_chk = 0;
    int n_fail = 0;
    exp_t q[$];
    logic [7:0] m_seq = 8'h0F, m_rem = 8'h00, m_mem = 8'h0F, m_rdy = 8'h0F;

    always #(CLK_PERIOD/2) clk = ~clk;

    rr_unit_selector #(.N(N)) u_rr_unit_selector (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_is_group(cfg_is_group),
        .cfg_units(cfg_units), .cfg_group_mask(cfg_group_mask), .req_valid(req_valid),
        .req_static(req_static), .req_unit(req_unit), .grant_o(grant_o), .use_i(use_i),
        .rel_i(rel_i), .misuse_o(misuse_o), .need_cnt(need_cnt), .reserved_i(reserved_i),
        .ready_o(ready_o), .ready_mask_o(ready_mask_o), .seq_mask_o(seq_mask_o)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] hib(logic [7:0] v);
        logic [7:0] r = '0;
        for (int i = 0; i < 8; i++) if (v[i]) begin r = '0; r[i] = 1'b1; end
        return r;
    endfunction

    function automatic logic [7:0] calc(bit isg, logic [3:0] k, logic [7:0] gm);
        logic [7:0] r;
        if (isg) r = gm ^ hib(gm);
        else for (int i = 0; i < 8; i++) r[i] = (i < int'(k));
        return (r == 0) ? 8'h01 : r;
    endfunction

    function automatic int pop(logic [7:0] v);
        int c = 0;
        for (int i = 0; i < 8; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic step(string tag, bit ld, bit isg, logic [3:0] k, logic [7:0] gm,
                        bit v, bit st, logic [7:0] u, logic [7:0] us, logic [7:0] rl,
                        logic [3:0] nd, bit rs);
        exp_t e;
        logic [7:0] bad, ns;
        @(negedge clk);
        cfg_load = ld; cfg_is_group = isg; cfg_units = k; cfg_group_mask = gm;
        req_valid = v; req_static = st; req_unit = u; use_i = us; rel_i = rl;
        need_cnt = nd; reserved_i = rs;
        e.tag = tag;
        bad   = (us & ~m_rdy) | (rl & m_rdy) | (us & rl);
        e.g   = ld ? 8'h00 : (v ? (st ? u : hib(m_seq)) : 8'h00);
        e.mis = !ld && (bad != 0);
        e.rq  = !rs && (pop(m_rdy) >= int'(nd));
        if (ld) begin
            m_mem = calc(isg, k, gm); m_seq = m_mem; m_rdy = m_mem; m_rem = 0;
        end else begin
            m_rdy = m_rdy ^ ((us | rl) & ~bad);
            if (v) begin
                ns = m_seq;
                if (!st) ns = m_seq & ~hib(m_seq);
                else if ((m_seq & u) != 0) ns = m_seq & ~u;
                else m_rem = m_rem | u;
                if (ns == 0) begin ns = m_mem & ~m_rem; m_rem = 0; end
                m_seq = ns;
            end
        end
        e.seq = m_seq; e.rdy = m_rdy;
        q.push_back(e);
    endtask

    task automatic pick(string tag);
        step(tag, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic consume(logic [7:0] u, string tag);
        step(tag, 0, 0, 0, 0, 1, 1, u, 0, 0, 0, 0);
    endtask
    task automatic rdyop(logic [7:0] us, logic [7:0] rl, logic [3:0] nd, bit rs, string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, us, rl, nd, rs);
    endtask
    task automatic cfg(bit isg, logic [3:0] k, logic [7:0] gm, bit v, string tag);
        step(tag, 1, isg, k, gm, v, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin : monitor
        exp_t cur, prev;
        bit have_prev = 0;
        forever begin
            @(negedge clk);
            #1;
            if (have_prev) begin
                chk(prev.tag, "seq_mask", 32'(seq_mask_o), 32'(prev.seq));
                chk(prev.tag, "ready_mask", 32'(ready_mask_o), 32'(prev.rdy));
            end
            have_prev = 0;
            if (q.size() > 0) begin
                cur = q.pop_front();
                chk(cur.tag, "grant", 32'(grant_o), 32'(cur.g));
                chk(cur.tag, "misuse", 32'(misuse_o), 32'(cur.mis));
                chk(cur.tag, "ready_q", 32'(ready_o), 32'(cur.rq));
                prev = cur;
                have_prev = 1;
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "reset seq", 32'(seq_mask_o), 32'h0F);
        chk("R1", "reset ready", 32'(ready_mask_o), 32'h0F);
        chk("R1", "idle grant", 32'(grant_o), 32'h0);
        chk("R1", "idle ready_q", 32'(ready_o), 32'h1);
        // R3 R4: descending walk and restart
        pick("R3"); pick("R4"); pick("R4"); pick("R4"); pick("R4");
        // R6: static consume of a unit still in the walk
        consume(8'h02, "R6"); pick("R6"); pick("R6");
        // R7 R5: consume a passed unit, refill excludes it once
        pick("R7"); consume(8'h08, "R7"); pick("R7"); pick("R7"); pick("R5");
        pick("R5"); pick("R5"); pick("R5"); pick("R5");
        // R8 R9 R10: ready mask and query
        rdyop(8'h03, 0, 4'd2, 0, "R8");
        rdyop(8'h01, 0, 4'd1, 0, "R9");
        rdyop(0, 8'h04, 4'd3, 0, "R9");
        rdyop(8'h04, 8'h04, 4'd2, 0, "R9");
        rdyop(0, 8'h03, 4'd2, 0, "R8");
        rdyop(0, 0, 4'd1, 1, "R10");
        rdyop(0, 0, 4'd5, 0, "R10");
        rdyop(0, 0, 4'd4, 0, "R10");
        // pick and use landing together
        step("R8", 0, 0, 0, 0, 1, 0, 0, 8'h08, 0, 0, 0);
        // R11 R2: load colliding with a pick, then several member sets
        cfg(1, 0, 8'hB0, 1, "R11");
        pick("R2"); pick("R2"); pick("R5");
        cfg(1, 0, 8'h40, 0, "R2");
        pick("R2"); pick("R2");
        cfg(0, 4'd8, 0, 0, "R2");
        pick("R2"); pick("R4");
        rdyop(0, 0, 4'd8, 0, "R10");
        repeat (3) @(negedge clk);
        req_valid = 0; use_i = 0; rel_i = 0; cfg_load = 0;
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule